// File: doc/BRIEF.md
# Coherent 64-bit Payload Byte Counter

This block keeps a running 64-bit total of the payload bytes that a processing unit pulls out of its output FIFO. On every clock a beat strobe arrives with a byte count for that beat and a parcel-kind tag. Only payload parcels add to the total. Context parcels, integrity-check-value parcels and the spare kind are dropped, so no byte enters the total twice. When an addition carries out of bit 63, the total keeps only its low 64 bits and a sticky wrap status flag is set. That flag, gated by an enable, drives an interrupt line.

Software reaches the 64-bit total through a 32-bit register port made of four strobes. To read, it fetches the low half first and then the high half. The low-half read latches the high half of the same value into a snapshot, and the high-half read returns that snapshot, so the pair stays coherent even while counting goes on. To write, it sends the high half first, which is held in a staging register. It then sends the low half, and all 64 bits load together in that cycle. The block assumes software keeps these orders and never interleaves a split read with a split write.

Top module: `payload_byte_counter`

## Requirements
- R1: After reset the total is zero, the wrap status and `irq` are low, and `reg_rdata` is zero while no read strobe is high.
- R2: A cycle with `beat_valid` high and `beat_kind` = 0 (payload) adds `beat_bytes` to the total at the clock edge. Kinds 1 (context), 2 (integrity check value) and 3 (spare) add nothing, and neither does a cycle with `beat_valid` low.
- R3: A payload beat whose `beat_bytes` exceeds 8 adds exactly 8.
- R4: An addition that carries past all ones leaves the total equal to the sum modulo 2^64 and sets the wrap status at that edge.
- R5: While `reg_rd_lo` is high, `reg_rdata` shows bits 31:0 of the current total, and bits 63:32 of the same value are latched. A later `reg_rd_hi` shows the latched bits, whatever counting happened in between.
- R6: `reg_wr_hi` stages `reg_wdata` and leaves the total unchanged. `reg_wr_lo` loads {staged word, `reg_wdata`} into the total at that edge.
- R7: When `reg_wr_lo` and a payload beat share a cycle, the load takes effect and that beat's bytes are discarded.
- R8: The wrap status stays set until a cycle with `sts_clear` high. If a wrap and a clear happen in the same cycle, the status stays set.
- R9: `irq` is high exactly when the wrap status is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A parcel beat is read from the output FIFO this cycle |
| beat_kind | input | 2 | Parcel kind: 0 payload, 1 context, 2 integrity check value, 3 spare |
| beat_bytes | input | 4 | Bytes in this beat, 0 to 8 (larger values count as 8) |
| reg_rd_lo | input | 1 | Read strobe for the low half; latches the high half |
| reg_rd_hi | input | 1 | Read strobe for the high half snapshot |
| reg_wr_hi | input | 1 | Write strobe for the high half staging register |
| reg_wr_lo | input | 1 | Write strobe for the low half; loads all 64 bits |
| reg_wdata | input | 32 | Write data for either half |
| reg_rdata | output | 32 | Read data for the strobed half, zero otherwise |
| sts_clear | input | 1 | Clears the wrap status |
| irq_en | input | 1 | Interrupt enable |
| wrap_status | output | 1 | Sticky wrap status flag |
| irq | output | 1 | Wrap status gated by the enable |

## Verification
Five properties are checked on every cycle. A non-payload beat leaves the total unchanged. Without a load or a wrap, the total never decreases. A wrap event is followed by the status flag. The status flag holds until cleared. A low-half load yields the staged word together with the written word. The high-half read is also checked against the high half latched by the previous low-half read. Other behaviour can only be seen in the bench's scenarios. These cover the exact sums for each parcel kind, clamping of oversized beats, wraps from values close to all ones, a clear that lands in the same cycle as a wrap, and a split read whose low half carries into the high half between its two halves.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    PK_PAYLOAD = 2'd0,
    PK_CONTEXT = 2'd1,
    PK_ICV     = 2'd2,
    PK_SPARE   = 2'd3
  } parcel_kind_e;

endpackage

// File: rtl/pbc_beat_filter.sv
module pbc_beat_filter
  import pbc_pkg::*;
#(
  parameter int MAX_BEAT = 8,
  parameter int BYTES_W  = 4,
  localparam int INC_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic               beat_valid,
  input  parcel_kind_e       beat_kind,
  input  logic [BYTES_W-1:0] beat_bytes,
  output logic               take,
  output logic [INC_W-1:0]   inc
);

  localparam logic [BYTES_W-1:0] LIMIT = BYTES_W'(MAX_BEAT);

  // Only payload parcels contribute to the total.
  function automatic logic counts_kind(parcel_kind_e k);
    return k == PK_PAYLOAD;
  endfunction

  // Oversized beats are clamped to the largest legal count.
  function automatic logic [INC_W-1:0] clamp_bytes(logic [BYTES_W-1:0] b);
    logic [BYTES_W-1:0] c;
    c = (b > LIMIT) ? LIMIT : b;
    return INC_W'(c);
  endfunction

  assign take = beat_valid && counts_kind(beat_kind);
  assign inc  = take ? clamp_bytes(beat_bytes) : '0;

endmodule

// File: rtl/pbc_count_core.sv
module pbc_count_core #(
  parameter int CNT_W = 64,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [INC_W-1:0] inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W:0] sum;

  // Widened add so the carry out of the top bit is visible.
  function automatic logic [CNT_W:0] add_inc(logic [CNT_W-1:0] c, logic [INC_W-1:0] i);
    return {1'b0, c} + {{(CNT_W + 1 - INC_W){1'b0}}, i};
  endfunction

  assign sum  = add_inc(count, inc);
  assign wrap = take && !load && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_value;
    end else if (take) begin
      count <= sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/pbc_split_port.sv
module pbc_split_port #(
  parameter int CNT_W   = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [HALF_W-1:0] rdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_value
);

  logic [HALF_W-1:0] snap_q;
  logic [HALF_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      stage_q <= '0;
    end else begin
      if (rd_lo) snap_q  <= count[CNT_W-1:HALF_W];
      if (wr_hi) stage_q <= wdata;
    end
  end

  always_comb begin
    if (rd_lo)      rdata = count[HALF_W-1:0];
    else if (rd_hi) rdata = snap_q;
    else            rdata = '0;
  end

  assign load       = wr_lo;
  assign load_value = {stage_q, wdata};

endmodule

// File: rtl/pbc_status.sv
module pbc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  input  logic en,
  output logic status,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)     status <= 1'b0;
    else if (set)   status <= 1'b1;
    else if (clear) status <= 1'b0;
  end

  assign irq = status && en;

endmodule

// File: rtl/payload_byte_counter.sv
module payload_byte_counter
  import pbc_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int MAX_BEAT = 8,
  parameter int BYTES_W  = 4,
  localparam int HALF_W  = CNT_W / 2,
  localparam int INC_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic [1:0]        beat_kind,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic              reg_rd_lo,
  input  logic              reg_rd_hi,
  input  logic              reg_wr_hi,
  input  logic              reg_wr_lo,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  input  logic              sts_clear,
  input  logic              irq_en,
  output logic              wrap_status,
  output logic              irq
);

  logic             take;
  logic [INC_W-1:0] inc;
  logic [CNT_W-1:0] count_q;
  logic             wrap_evt;
  logic             load_evt;
  logic [CNT_W-1:0] load_value;

  pbc_beat_filter #(.MAX_BEAT(MAX_BEAT), .BYTES_W(BYTES_W)) u_filter (
    .beat_valid (beat_valid),
    .beat_kind  (parcel_kind_e'(beat_kind)),
    .beat_bytes (beat_bytes),
    .take       (take),
    .inc        (inc)
  );

  pbc_count_core #(.CNT_W(CNT_W), .INC_W(INC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .inc        (inc),
    .load       (load_evt),
    .load_value (load_value),
    .count      (count_q),
    .wrap       (wrap_evt)
  );

  pbc_split_port #(.CNT_W(CNT_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_lo      (reg_rd_lo),
    .rd_hi      (reg_rd_hi),
    .wr_hi      (reg_wr_hi),
    .wr_lo      (reg_wr_lo),
    .wdata      (reg_wdata),
    .count      (count_q),
    .rdata      (reg_rdata),
    .load       (load_evt),
    .load_value (load_value)
  );

  pbc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (wrap_evt),
    .clear  (sts_clear),
    .en     (irq_en),
    .status (wrap_status),
    .irq    (irq)
  );

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int CNT_W   = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic [1:0]        beat_kind,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              wr_lo,
  input logic [HALF_W-1:0] rdata,
  input logic              sts_clear,
  input logic              status,
  input logic [CNT_W-1:0]  count,
  input logic              wrap_evt,
  input logic              load_evt,
  input logic [CNT_W-1:0]  load_value
);

  // R2: a non-payload beat without a load leaves the total alone
  assert_excluded_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_kind != 2'd0 && !load_evt) |=> count == $past(count));

  // R4: no load and no wrap means the total cannot shrink
  assert_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !wrap_evt) |=> count >= $past(count));

  // R4: a wrap event raises the status flag
  assert_wrap_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> status);

  // R8: status holds until a clear
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !sts_clear) |=> status);

  // R7: a low-half write loads the assembled value regardless of counting
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> count == $past(load_value));

  // R5: a high read right after a low read returns the latched high half
  assert_hi_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_lo) |=> (rd_hi && !rd_lo) |-> rdata == $past(count[CNT_W-1:HALF_W]));

endmodule

bind payload_byte_counter pbc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat_valid (beat_valid),
  .beat_kind  (beat_kind),
  .rd_lo      (reg_rd_lo),
  .rd_hi      (reg_rd_hi),
  .wr_lo      (reg_wr_lo),
  .rdata      (reg_rdata),
  .sts_clear  (sts_clear),
  .status     (wrap_status),
  .count      (count_q),
  .wrap_evt   (wrap_evt),
  .load_evt   (load_evt),
  .load_value (load_value)
);

// File: tb/sim_payload_byte_counter.sv
module sim_payload_byte_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_valid = 1'b0;
  logic [1:0]  beat_kind = 2'd0;
  logic [3:0]  beat_bytes = 4'd0;
  logic        reg_rd_lo = 1'b0;
  logic        reg_rd_hi = 1'b0;
  logic        reg_wr_hi = 1'b0;
  logic        reg_wr_lo = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        sts_clear = 1'b0;
  logic        irq_en = 1'b0;
  logic        wrap_status;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  payload_byte_counter u0 (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_kind(beat_kind),
    .beat_bytes(beat_bytes), .reg_rd_lo(reg_rd_lo), .reg_rd_hi(reg_rd_hi),
    .reg_wr_hi(reg_wr_hi), .reg_wr_lo(reg_wr_lo), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sts_clear(sts_clear), .irq_en(irq_en),
    .wrap_status(wrap_status), .irq(irq)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read64(output logic [63:0] v);
    logic [31:0] lo, hi;
    reg_rd_lo = 1'b1; #1 lo = reg_rdata; tick();
    reg_rd_lo = 1'b0; reg_rd_hi = 1'b1; #1 hi = reg_rdata; tick();
    reg_rd_hi = 1'b0;
    v = {hi, lo};
  endtask

  task automatic load64(logic [63:0] v);
    reg_wr_hi = 1'b1; reg_wdata = v[63:32]; tick();
    reg_wr_hi = 1'b0; reg_wr_lo = 1'b1; reg_wdata = v[31:0]; tick();
    reg_wr_lo = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic beat(logic [1:0] kind, logic [3:0] bytes);
    beat_valid = 1'b1; beat_kind = kind; beat_bytes = bytes; tick();
    beat_valid = 1'b0; beat_kind = 2'd0; beat_bytes = 4'd0;
  endtask

  task automatic clear_status();
    sts_clear = 1'b1; tick(); sts_clear = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 rdata idle", {32'd0, reg_rdata}, 64'd0);
    check("R1 status", {63'd0, wrap_status}, 64'd0);
    check("R1 irq", {63'd0, irq}, 64'd0);
    read64(v);
    check("R1 total", v, 64'd0);
  endtask

  task automatic t_kinds();
    logic [63:0] v;
    load64(64'd0);
    beat(2'd0, 4'd5);
    beat(2'd1, 4'd7);
    beat(2'd2, 4'd3);
    beat(2'd3, 4'd8);
    beat_kind = 2'd0; beat_bytes = 4'd6; tick(); beat_bytes = 4'd0;
    beat(2'd0, 4'd8);
    beat(2'd0, 4'd0);
    read64(v);
    check("R2 payload only", v, 64'd13);
  endtask

  task automatic t_clamp();
    logic [63:0] v;
    load64(64'd100);
    beat(2'd0, 4'd15);
    beat(2'd0, 4'd9);
    read64(v);
    check("R3 clamp to 8", v, 64'd116);
  endtask

  task automatic t_write();
    logic [63:0] v;
    load64(64'h0123_4567_89AB_CDEF);
    read64(v);
    check("R6 load", v, 64'h0123_4567_89AB_CDEF);
    reg_wr_hi = 1'b1; reg_wdata = 32'hDEAD_BEEF; tick(); reg_wr_hi = 1'b0;
    read64(v);
    check("R6 staging only", v, 64'h0123_4567_89AB_CDEF);
    reg_wr_lo = 1'b1; reg_wdata = 32'h0000_0010; tick(); reg_wr_lo = 1'b0;
    read64(v);
    check("R6 staged high used", v, 64'hDEAD_BEEF_0000_0010);
  endtask

  task automatic t_load_wins();
    logic [63:0] v;
    reg_wr_hi = 1'b1; reg_wdata = 32'h1234_5678; tick(); reg_wr_hi = 1'b0;
    reg_wr_lo = 1'b1; reg_wdata = 32'h9ABC_DEF0;
    beat_valid = 1'b1; beat_kind = 2'd0; beat_bytes = 4'd8; tick();
    reg_wr_lo = 1'b0; beat_valid = 1'b0; beat_bytes = 4'd0;
    read64(v);
    check("R7 load beats count", v, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_coherent();
    logic [31:0] lo, hi;
    logic [63:0] v;
    load64(64'h0000_0000_FFFF_FFFC);
    reg_rd_lo = 1'b1;
    beat_valid = 1'b1; beat_kind = 2'd0; beat_bytes = 4'd8;
    #1 lo = reg_rdata; tick();
    reg_rd_lo = 1'b0; beat_valid = 1'b0; beat_bytes = 4'd0;
    reg_rd_hi = 1'b1; #1 hi = reg_rdata; tick(); reg_rd_hi = 1'b0;
    check("R5 coherent pair", {hi, lo}, 64'h0000_0000_FFFF_FFFC);
    read64(v);
    check("R5 carried value", v, 64'h0000_0001_0000_0004);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    clear_status();
    load64(64'hFFFF_FFFF_FFFF_FFFD);
    beat(2'd0, 4'd5);
    read64(v);
    check("R4 wrapped total", v, 64'd2);
    check("R4 status set", {63'd0, wrap_status}, 64'd1);
    irq_en = 1'b0; #1;
    check("R9 irq masked", {63'd0, irq}, 64'd0);
    irq_en = 1'b1; #1;
    check("R9 irq enabled", {63'd0, irq}, 64'd1);
    beat(2'd0, 4'd8); tick();
    check("R8 status sticky", {63'd0, wrap_status}, 64'd1);
    clear_status();
    check("R8 cleared", {63'd0, wrap_status}, 64'd0);
    check("R9 irq low after clear", {63'd0, irq}, 64'd0);
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 no wrap on load", {63'd0, wrap_status}, 64'd0);
    sts_clear = 1'b1; beat_valid = 1'b1; beat_kind = 2'd0; beat_bytes = 4'd1; tick();
    sts_clear = 1'b0; beat_valid = 1'b0; beat_bytes = 4'd0;
    check("R8 set beats clear", {63'd0, wrap_status}, 64'd1);
    read64(v);
    check("R4 exact wrap", v, 64'd0);
    clear_status();
    load64(64'hFFFF_FFFF_FFFF_FFF8);
    beat(2'd0, 4'd7);
    check("R4 no wrap below top", {63'd0, wrap_status}, 64'd0);
    beat(2'd2, 4'd8);
    check("R2 excluded no wrap", {63'd0, wrap_status}, 64'd0);
    irq_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_kinds();
    t_clamp();
    t_write();
    t_load_wins();
    t_coherent();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule